// File: doc/BRIEF.md
# Host/Adapter Mailbox Doorbell and Interrupt Logic

This block sits between a host processor and an adapter that trade command and reply blocks through shared memory. It keeps four 8-bit registers. Two face the host: the adapter raises event bits in them and the host acknowledges each event by clearing it. Two face the adapter: the host rings doorbells in them and the adapter clears each doorbell once it has handled it. The block drives a single host interrupt line, gated by a master enable. It also gives the adapter a one-cycle pulse for every doorbell the host rings, plus an adapter interrupt line for internal status.

The host reaches the registers through a small access port. Each access selects a register and one of three operations: write, bitwise AND, or bitwise OR. Two doorbells ask to be notified when a resource is free. If the host sets one of them while the earlier command or status block is still busy, the block turns the adapter's later completion strobe into a host event.

Top module: `mbox_irq_hs`

## Requirements
- R1: After reset all four registers read 0x00, and `host_irq`, `adp_irq` and `bell_pulse` are low.
- R2: `host_irq` is high exactly when bit 6 (master enable) of the host-low register is 1 and at least one event bit is set: bits 4, 3 or 2 of host-low, or bits 6..1 of host-high.
- R3: Adapter event strobes set host-low bits 4, 3, 2 and host-high bits 6, 5, 3, 2, 1 on the next clock. A host AND clears each event bit whose data bit is 0. A host write or OR never sets an event bit.
- R4: When a set and a clear of the same bit land in the same cycle, the set wins. This holds for an adapter event against a host AND, and for a host doorbell OR against an adapter doorbell clear.
- R5: A host OR to adapter-high sets the named bits among 5, 4, 1, 0 (command posted, reply posted, release request block, release status block). Such a bit stays set until `adp_bell_clr` clears it. A host write or AND to adapter-high has no effect.
- R6: `bell_pulse[i]` for a doorbell bit i in {5, 4, 1, 0} is high for exactly one cycle, in the first cycle the bit reads set after being clear. No pulse comes while bit 0 of adapter-low (software mask) is 1, but the doorbell still latches.
- R7: If adapter-high bit 3 (notify when command done) is set and `adp_cmd_done` strobes, host-high bit 5 sets and adapter-high bit 3 clears on the next clock. `adp_cmd_done` has no effect while bit 3 is clear.
- R8: Host-high bit 4 (status block free) sets only through `adp_sb_copied`, and only when adapter-high bit 2 (notify when status block free) is set or `adp_resp_err` is high. In the first case bit 2 clears. Event input bit 4 of `adp_evt_hi` is ignored.
- R9: Host-low bits 6 and 0, and adapter-low bits 1 and 0, follow the host write, AND and OR operations directly.
- R10: `adp_stat` sets adapter-low bits 7..3, and a host AND clears them. `adp_irq` is high when any of these bits is set and adapter-low bit 1 (hardware mask) is 0.
- R11: `host_rdata` shows the register picked by `host_sel` in the same cycle: 0 host-low, 1 host-high, 2 adapter-low, 3 adapter-high. `host_op` codes: 0 write, 1 AND, 2 OR, 3 read only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_op | input | 2 | Access operation: 0 write, 1 AND, 2 OR, 3 read |
| host_sel | input | 2 | Register select |
| host_wdata | input | 8 | Host operand |
| host_rdata | output | 8 | Selected register contents |
| host_irq | output | 1 | Gated host interrupt |
| adp_evt_lo | input | 8 | Adapter event set mask for host-low |
| adp_evt_hi | input | 8 | Adapter event set mask for host-high |
| adp_stat | input | 8 | Adapter status set mask for adapter-low |
| adp_bell_clr | input | 8 | Adapter doorbell clear mask for adapter-high |
| adp_cmd_done | input | 1 | Earlier command finished |
| adp_sb_copied | input | 1 | Earlier status block consumed |
| adp_resp_err | input | 1 | Error found in the host's status block |
| adp_irq | output | 1 | Adapter internal-status interrupt |
| bell_pulse | output | 8 | Per-doorbell one-cycle pulses |

## Verification
Two paths can hit the same bit in one cycle. On the host side, an adapter event strobe can meet a host AND that clears that bit. On the adapter side, a host doorbell OR can meet an adapter clear of that doorbell. The bench drives both requests in one access cycle and reads the register back on the next cycle; the bit must be set. In the doorbell case it also checks that a pulse appears only when the bit was clear before.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_RD  = 2'd3
    } hop_e;

    typedef enum logic [1:0] {
        SEL_HLO = 2'd0,
        SEL_HHI = 2'd1,
        SEL_ALO = 2'd2,
        SEL_AHI = 2'd3
    } hsel_e;

    // host-low: master enable (6), adapter select (0) / events 4,3,2
    localparam int               HLO_IEN_BIT = 6;
    localparam logic [DW-1:0]    HLO_CTRL    = 8'h41;
    localparam logic [DW-1:0]    HLO_EVT     = 8'h1C;

    // host-high: events 6..1; bit 4 only via the free-notify path
    localparam int               HHI_RSP_BIT  = 5;
    localparam int               HHI_FREE_BIT = 4;
    localparam logic [DW-1:0]    HHI_EVT      = 8'h7E;
    localparam logic [DW-1:0]    HHI_ADP_SET  = 8'h6E;

    // adapter-low: masks 1,0 / status 7..3
    localparam int               ALO_HWM_BIT = 1;
    localparam int               ALO_SWM_BIT = 0;
    localparam logic [DW-1:0]    ALO_CTRL    = 8'h03;
    localparam logic [DW-1:0]    ALO_STAT    = 8'hF8;

    // adapter-high: doorbells 5,4,1,0 / notify requests 3,2
    localparam int               AHI_CMD_NFY = 3;
    localparam int               AHI_SB_NFY  = 2;
    localparam logic [DW-1:0]    AHI_BELL    = 8'h33;
    localparam logic [DW-1:0]    AHI_ALL     = 8'h3F;

    function automatic logic [DW-1:0] ctrl_next(
        input logic [DW-1:0] cur,
        input hop_e          op,
        input logic [DW-1:0] opnd
    );
        logic [DW-1:0] r;
        case (op)
            OP_WR:   r = opnd;
            OP_AND:  r = cur & opnd;
            OP_OR:   r = cur | opnd;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_en,
    input  hop_e          host_op,
    input  hsel_e         host_sel,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] adp_evt_lo,
    input  logic [DW-1:0] adp_evt_hi,
    input  logic          rsp_fire,
    input  logic          free_fire,
    output logic [DW-1:0] hlo_o,
    output logic [DW-1:0] hhi_o
);

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } hst_t;

    hst_t          st_d, st_q;
    logic          hit_lo, hit_hi;
    logic [DW-1:0] clr_lo, clr_hi, set_lo, set_hi, ctl_lo;

    always_comb begin
        hit_lo = host_en && (host_sel == SEL_HLO);
        hit_hi = host_en && (host_sel == SEL_HHI);

        clr_lo = (hit_lo && host_op == OP_AND) ? (~host_wdata & HLO_EVT) : '0;
        clr_hi = (hit_hi && host_op == OP_AND) ? (~host_wdata & HHI_EVT) : '0;

        set_lo = adp_evt_lo & HLO_EVT;
        set_hi = adp_evt_hi & HHI_ADP_SET;
        if (rsp_fire)  set_hi[HHI_RSP_BIT]  = 1'b1;
        if (free_fire) set_hi[HHI_FREE_BIT] = 1'b1;

        ctl_lo = hit_lo ? ctrl_next(st_q.lo, host_op, host_wdata) : st_q.lo;

        st_d.lo = (ctl_lo & HLO_CTRL)
                | (((st_q.lo & ~clr_lo) | set_lo) & HLO_EVT);
        st_d.hi = ((st_q.hi & ~clr_hi) | set_hi) & HHI_EVT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hlo_o = st_q.lo;
    assign hhi_o = st_q.hi;

endmodule

// File: rtl/mbox_adp_regs.sv
module mbox_adp_regs
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_en,
    input  hop_e          host_op,
    input  hsel_e         host_sel,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] adp_stat,
    input  logic [DW-1:0] adp_bell_clr,
    input  logic          adp_cmd_done,
    input  logic          adp_sb_copied,
    input  logic          adp_resp_err,
    output logic          rsp_fire,
    output logic          free_fire,
    output logic [DW-1:0] alo_o,
    output logic [DW-1:0] ahi_o,
    output logic [DW-1:0] pulse_o
);

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] pulse;
    } ast_t;

    ast_t          st_d, st_q;
    logic          hit_lo, hit_hi;
    logic [DW-1:0] clr_stat, set_stat, ctl_lo;
    logic [DW-1:0] bell_set, bell_clr;
    logic [DW-1:0] lo_n, hi_n, pulse_n;

    always_comb begin
        hit_lo = host_en && (host_sel == SEL_ALO);
        hit_hi = host_en && (host_sel == SEL_AHI);

        rsp_fire  = adp_cmd_done && st_q.hi[AHI_CMD_NFY];
        free_fire = adp_sb_copied && (st_q.hi[AHI_SB_NFY] || adp_resp_err);

        clr_stat = (hit_lo && host_op == OP_AND) ? (~host_wdata & ALO_STAT) : '0;
        set_stat = adp_stat & ALO_STAT;
        ctl_lo   = hit_lo ? ctrl_next(st_q.lo, host_op, host_wdata) : st_q.lo;
        lo_n     = (ctl_lo & ALO_CTRL)
                 | (((st_q.lo & ~clr_stat) | set_stat) & ALO_STAT);

        bell_set = (hit_hi && host_op == OP_OR) ? (host_wdata & AHI_ALL) : '0;
        bell_clr = adp_bell_clr & AHI_BELL;
        if (rsp_fire)                                 bell_clr[AHI_CMD_NFY] = 1'b1;
        if (adp_sb_copied && st_q.hi[AHI_SB_NFY])     bell_clr[AHI_SB_NFY]  = 1'b1;
        hi_n = ((st_q.hi & ~bell_clr) | bell_set) & AHI_ALL;
    end

    for (genvar i = 0; i < DW; i++) begin : g_pulse
        if (AHI_BELL[i]) begin : g_bell
            assign pulse_n[i] = hi_n[i] & ~st_q.hi[i] & ~st_q.lo[ALO_SWM_BIT];
        end else begin : g_none
            assign pulse_n[i] = 1'b0;
        end
    end

    always_comb begin
        st_d.lo    = lo_n;
        st_d.hi    = hi_n;
        st_d.pulse = pulse_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alo_o   = st_q.lo;
    assign ahi_o   = st_q.hi;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/mbox_irq_gate.sv
module mbox_irq_gate
    import mbox_pkg::*;
(
    input  logic [DW-1:0] hlo,
    input  logic [DW-1:0] hhi,
    input  logic [DW-1:0] alo,
    output logic          host_irq,
    output logic          adp_irq
);

    logic any_host_evt, any_adp_stat;

    always_comb begin
        any_host_evt = (|(hlo & HLO_EVT)) || (|(hhi & HHI_EVT));
        any_adp_stat = |(alo & ALO_STAT);
        host_irq     = hlo[HLO_IEN_BIT] && any_host_evt;
        adp_irq      = !alo[ALO_HWM_BIT] && any_adp_stat;
    end

endmodule

// File: rtl/mbox_irq_hs.sv
module mbox_irq_hs
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_en,
    input  logic [1:0]    host_op,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_irq,
    input  logic [DW-1:0] adp_evt_lo,
    input  logic [DW-1:0] adp_evt_hi,
    input  logic [DW-1:0] adp_stat,
    input  logic [DW-1:0] adp_bell_clr,
    input  logic          adp_cmd_done,
    input  logic          adp_sb_copied,
    input  logic          adp_resp_err,
    output logic          adp_irq,
    output logic [DW-1:0] bell_pulse
);

    hop_e          op_t;
    hsel_e         sel_t;
    logic [DW-1:0] hlo_q, hhi_q, alo_q, ahi_q;
    logic          rsp_fire, free_fire;

    assign op_t  = hop_e'(host_op);
    assign sel_t = hsel_e'(host_sel);

    mbox_host_regs u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_en    (host_en),
        .host_op    (op_t),
        .host_sel   (sel_t),
        .host_wdata (host_wdata),
        .adp_evt_lo (adp_evt_lo),
        .adp_evt_hi (adp_evt_hi),
        .rsp_fire   (rsp_fire),
        .free_fire  (free_fire),
        .hlo_o      (hlo_q),
        .hhi_o      (hhi_q)
    );

    mbox_adp_regs u_adp (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_en       (host_en),
        .host_op       (op_t),
        .host_sel      (sel_t),
        .host_wdata    (host_wdata),
        .adp_stat      (adp_stat),
        .adp_bell_clr  (adp_bell_clr),
        .adp_cmd_done  (adp_cmd_done),
        .adp_sb_copied (adp_sb_copied),
        .adp_resp_err  (adp_resp_err),
        .rsp_fire      (rsp_fire),
        .free_fire     (free_fire),
        .alo_o         (alo_q),
        .ahi_o         (ahi_q),
        .pulse_o       (bell_pulse)
    );

    mbox_irq_gate u_gate (
        .hlo      (hlo_q),
        .hhi      (hhi_q),
        .alo      (alo_q),
        .host_irq (host_irq),
        .adp_irq  (adp_irq)
    );

    always_comb begin
        case (sel_t)
            SEL_HLO: host_rdata = hlo_q;
            SEL_HHI: host_rdata = hhi_q;
            SEL_ALO: host_rdata = alo_q;
            default: host_rdata = ahi_q;
        endcase
    end

endmodule

// File: rtl/mbox_irq_hs_chk.sv
module mbox_irq_hs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] hlo,
    input logic [7:0] hhi,
    input logic [7:0] alo,
    input logic [7:0] ahi,
    input logic       host_irq,
    input logic       adp_irq,
    input logic [7:0] bell_pulse,
    input logic [7:0] adp_bell_clr,
    input logic       adp_cmd_done,
    input logic       adp_sb_copied,
    input logic       adp_resp_err
);

    // R2: master enable off forces the host line low
    a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !hlo[6] |-> !host_irq);

    // R5: a rung doorbell not cleared by the adapter stays set
    a_r5_bell_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ahi & ~adp_bell_clr & 8'h33)) |=>
        ((ahi & $past(ahi & ~adp_bell_clr & 8'h33)) == $past(ahi & ~adp_bell_clr & 8'h33)));

    // R6: no doorbell pulse lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|bell_pulse) |=> ((bell_pulse & $past(bell_pulse)) == 8'h00));

    // R7: command-done with notify armed raises the reply event
    a_r7_notify_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_cmd_done && ahi[3]) |=> hhi[5]);

    // R8: status-block-free event stays low without an enabled cause
    a_r8_free_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!hhi[4] && !(adp_sb_copied && (ahi[2] || adp_resp_err))) |=> !hhi[4]);

    // R10: hardware mask blocks the adapter interrupt
    a_r10_hw_mask: assert property (@(posedge clk) disable iff (!rst_n)
        alo[1] |-> !adp_irq);

endmodule

bind mbox_irq_hs mbox_irq_hs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hlo           (hlo_q),
    .hhi           (hhi_q),
    .alo           (alo_q),
    .ahi           (ahi_q),
    .host_irq      (host_irq),
    .adp_irq       (adp_irq),
    .bell_pulse    (bell_pulse),
    .adp_bell_clr  (adp_bell_clr),
    .adp_cmd_done  (adp_cmd_done),
    .adp_sb_copied (adp_sb_copied),
    .adp_resp_err  (adp_resp_err)
);

// File: tb/mbox_irq_hs_test.sv
`timescale 1ns/100ps
module mbox_irq_hs_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_en;
    logic [1:0] host_op, host_sel;
    logic [7:0] host_wdata, host_rdata;
    logic       host_irq, adp_irq;
    logic [7:0] adp_evt_lo, adp_evt_hi, adp_stat, adp_bell_clr, bell_pulse;
    logic       adp_cmd_done, adp_sb_copied, adp_resp_err;

    always #2.5 clk = ~clk;

    mbox_irq_hs uut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_op(host_op),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .adp_evt_lo(adp_evt_lo), .adp_evt_hi(adp_evt_hi),
        .adp_stat(adp_stat), .adp_bell_clr(adp_bell_clr),
        .adp_cmd_done(adp_cmd_done), .adp_sb_copied(adp_sb_copied),
        .adp_resp_err(adp_resp_err), .adp_irq(adp_irq), .bell_pulse(bell_pulse)
    );

    typedef struct {
        string      req;
        int         kind;   // 0 register, 1 host_irq, 2 adp_irq, 3 bell_pulse
        logic [1:0] sel;
        logic [7:0] exp;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    event go, done;

    task automatic exp_reg(string req, logic [1:0] sel, logic [7:0] v);
        exp_t e;
        e.req = req; e.kind = 0; e.sel = sel; e.exp = v;
        sbq.push_back(e);
    endtask

    task automatic exp_sig(string req, int kind, logic [7:0] v);
        exp_t e;
        e.req = req; e.kind = kind; e.sel = 2'd0; e.exp = v;
        sbq.push_back(e);
    endtask

    task automatic settle();
        ->go;
        @(done);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        exp_t       e;
        logic [7:0] act;
        forever begin
            @(go);
            while (sbq.size() > 0) begin
                e = sbq.pop_front();
                case (e.kind)
                    0: begin host_sel = e.sel; #0.1; act = host_rdata; end
                    1: begin #0.1; act = {7'd0, host_irq}; end
                    2: begin #0.1; act = {7'd0, adp_irq}; end
                    default: begin #0.1; act = bell_pulse; end
                endcase
                n_chk++;
                if (act !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d sel=%0d: actual=%h expected=%h",
                             e.req, e.kind, e.sel, act, e.exp);
                end
            end
            ->done;
        end
    end

    task automatic idle_in();
        host_en = 0; host_op = 2'd3; host_wdata = 8'h00;
        adp_evt_lo = 0; adp_evt_hi = 0; adp_stat = 0; adp_bell_clr = 0;
        adp_cmd_done = 0; adp_sb_copied = 0; adp_resp_err = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle_in();
    endtask

    task automatic hacc(logic [1:0] op, logic [1:0] sel, logic [7:0] d);
        host_en = 1; host_op = op; host_sel = sel; host_wdata = d;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        host_sel = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state (R11 select decode)
        exp_reg("R1", 0, 8'h00); exp_reg("R1", 1, 8'h00);
        exp_reg("R1", 2, 8'h00); exp_reg("R11", 3, 8'h00);
        exp_sig("R1", 1, 0); exp_sig("R1", 2, 0); exp_sig("R1", 3, 0);
        settle();

        // R9/R3: write all ones -> only control bits take
        hacc(0, 0, 8'hFF); tick();
        exp_reg("R9", 0, 8'h41); exp_sig("R2", 1, 0); settle();

        // R3/R2: timer event raises interrupt
        adp_evt_lo = 8'h10; tick();
        exp_reg("R3", 0, 8'h51); exp_sig("R2", 1, 1); settle();

        // R2: drop master enable
        hacc(0, 0, 8'h01); tick();
        exp_reg("R2", 0, 8'h11); exp_sig("R2", 1, 0); settle();

        // R9: OR enable back
        hacc(2, 0, 8'h40); tick();
        exp_reg("R9", 0, 8'h51); exp_sig("R2", 1, 1); settle();

        // R3: AND clears the event
        hacc(1, 0, 8'hEF); tick();
        exp_reg("R3", 0, 8'h41); exp_sig("R2", 1, 0); settle();

        // R3/R8: all host-high events, bit 4 ignored
        adp_evt_hi = 8'hFF; tick();
        exp_reg("R8", 1, 8'h6E); exp_sig("R2", 1, 1); settle();

        // R3: host OR cannot set event bits
        hacc(2, 1, 8'hFF); tick();
        exp_reg("R3", 1, 8'h6E); settle();

        // R4: clear-all AND meets adapter set of bit 2
        hacc(1, 1, 8'h00); adp_evt_hi = 8'h04; tick();
        exp_reg("R4", 1, 8'h04); exp_sig("R2", 1, 1); settle();

        hacc(1, 1, 8'h00); tick();
        exp_reg("R3", 1, 8'h00); exp_sig("R2", 1, 0); settle();

        // R5/R6: ring command doorbell
        hacc(2, 3, 8'h20); tick();
        exp_reg("R5", 3, 8'h20); exp_sig("R6", 3, 8'h20); settle();
        tick();
        exp_reg("R5", 3, 8'h20); exp_sig("R6", 3, 8'h00); settle();

        // R5: write and AND have no effect on adapter-high
        hacc(0, 3, 8'h00); tick();
        hacc(1, 3, 8'h00); tick();
        exp_reg("R5", 3, 8'h20); exp_sig("R6", 3, 8'h00); settle();

        adp_bell_clr = 8'h20; tick();
        exp_reg("R5", 3, 8'h00); settle();

        // R4/R6: host rings bit 0 while adapter clears it
        hacc(2, 3, 8'h01); adp_bell_clr = 8'h01; tick();
        exp_reg("R4", 3, 8'h01); exp_sig("R6", 3, 8'h01); settle();
        adp_bell_clr = 8'h01; tick();
        exp_reg("R5", 3, 8'h00); settle();

        // R6: software mask suppresses pulse, doorbell still latches
        hacc(0, 2, 8'h01); tick();
        exp_reg("R9", 2, 8'h01); settle();
        hacc(2, 3, 8'h10); tick();
        exp_reg("R6", 3, 8'h10); exp_sig("R6", 3, 8'h00); settle();
        adp_bell_clr = 8'h10; tick();
        hacc(0, 2, 8'h00); tick();
        exp_reg("R5", 3, 8'h00); exp_reg("R9", 2, 8'h00); settle();

        // R7: done without notify does nothing
        adp_cmd_done = 1; tick();
        exp_reg("R7", 1, 8'h00); settle();
        hacc(2, 3, 8'h08); tick();
        exp_reg("R7", 3, 8'h08); exp_sig("R6", 3, 8'h00); settle();
        adp_cmd_done = 1; tick();
        exp_reg("R7", 1, 8'h20); exp_reg("R7", 3, 8'h00); exp_sig("R2", 1, 1); settle();
        hacc(1, 1, 8'h00); tick();

        // R8: copied alone does nothing; error path sets; notify path sets
        adp_sb_copied = 1; tick();
        exp_reg("R8", 1, 8'h00); settle();
        adp_sb_copied = 1; adp_resp_err = 1; tick();
        exp_reg("R8", 1, 8'h10); settle();
        hacc(1, 1, 8'h00); tick();
        hacc(2, 3, 8'h04); tick();
        exp_reg("R8", 3, 8'h04); settle();
        adp_sb_copied = 1; tick();
        exp_reg("R8", 1, 8'h10); exp_reg("R8", 3, 8'h00); settle();
        hacc(1, 1, 8'h00); tick();
        exp_reg("R3", 1, 8'h00); settle();

        // R10: adapter status and hardware mask
        adp_stat = 8'hFF; tick();
        exp_reg("R10", 2, 8'hF8); exp_sig("R10", 2, 1); settle();
        hacc(0, 2, 8'h02); tick();
        exp_reg("R10", 2, 8'hFA); exp_sig("R10", 2, 0); settle();
        hacc(1, 2, 8'h07); tick();
        exp_reg("R10", 2, 8'h02); exp_sig("R10", 2, 0); settle();
        hacc(0, 2, 8'h00); adp_stat = 8'h08; tick();
        exp_reg("R10", 2, 8'h08); exp_sig("R10", 2, 1); settle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule